// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a bank of already-synchronised input pins and raises an interrupt when a pin meets the condition chosen for it. Each pin has its own enable bit and a two-bit trigger selector. The selector is split across two vectors, a high half and a low half. Together they choose between a high level, a low level, a rising edge and a falling edge. A pin whose condition holds while it is enabled sets a sticky pending bit. All pending bits are ORed into one registered interrupt line.

The surrounding register file decodes the bus and owns the enable and selector registers. It passes these to the block as plain vectors. It also passes a one-cycle strobe whenever software reads the pending register. The block presents the pending vector as the read data, and clears it on the edge that ends the read. A trigger event that lands in the same cycle as the read is kept. Turning off a pin's enable also drops that pin's pending bit.

Top module: `pin_event_detect`

## Requirements
- R1: After a clock edge with `rst` high, `stat_out` and `irq_out` are all zero, and the stored previous sample of every pin is zero.
- R2: With selector {`trig_hi`,`trig_lo`} = 2'b00 and the pin enabled, a high `pin_in` bit sets that pin's `stat_out` bit on the same clock edge.
- R3: With selector 2'b01 and the pin enabled, a low `pin_in` bit sets the pin's status bit on the same clock edge.
- R4: With selector 2'b10, the bit is set only when `pin_in` is 1 at an edge and was 0 at the previous edge.
- R5: With selector 2'b11, the bit is set only when `pin_in` is 0 at an edge and was 1 at the previous edge.
- R6: A set status bit stays set while its pin remains enabled and `stat_rd` stays low, even after the trigger condition goes away.
- R7: While `irq_en` bit i is 0, status bit i cannot be set. An enable of 0 also clears a pending bit on the next edge.
- R8: An edge with `stat_rd` high clears every status bit that has no trigger event in that cycle.
- R9: A trigger event in the same cycle as `stat_rd` leaves the bit set. An active level therefore keeps its bit set through a read.
- R10: `irq_out` is registered. After each edge it equals the OR of `stat_out` as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronised pin levels |
| irq_en | input | NUM_PINS | Per-pin interrupt enable |
| trig_hi | input | NUM_PINS | Upper bit of each pin's trigger selector |
| trig_lo | input | NUM_PINS | Lower bit of each pin's trigger selector |
| stat_rd | input | 1 | One-cycle strobe marking a read of the pending register |
| stat_out | output | NUM_PINS | Pending status vector (read data) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_PINS set to 8. At that width, every pin can be given a different selector and enable at once, so all four trigger kinds run side by side. A reference model that is separate from the RTL steps each cycle, so reads can collide with edges, with persisting levels and with enable changes in the same cycle. The width also lets a walk over every bit show that each pin acts on its own, with no spill into its neighbours.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_kind_e;

    typedef struct packed {
        logic now_lvl;
        logic old_lvl;
    } pin_sample_t;

    function automatic trig_kind_e make_kind(input logic hi, input logic lo);
        return trig_kind_e'({hi, lo});
    endfunction

    function automatic logic trig_hit(input trig_kind_e kind, input pin_sample_t s);
        logic r;
        unique case (kind)
            TRIG_HIGH: r = s.now_lvl;
            TRIG_LOW:  r = ~s.now_lvl;
            TRIG_RISE: r = s.now_lvl & ~s.old_lvl;
            TRIG_FALL: r = ~s.now_lvl & s.old_lvl;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pin_event_history.sv
module pin_event_history #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] old_q
);
    always_ff @(posedge clk) begin
        if (rst) old_q <= '0;
        else     old_q <= pin_in;
    end
endmodule

// File: rtl/pin_event_match.sv
module pin_event_match
    import pin_event_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] old_lvl,
    input  logic [NUM_PINS-1:0] irq_en,
    input  logic [NUM_PINS-1:0] trig_hi,
    input  logic [NUM_PINS-1:0] trig_lo,
    output logic [NUM_PINS-1:0] hit
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pin_sample_t smp;
        trig_kind_e  kind;
        always_comb begin
            smp.now_lvl = pin_in[g];
            smp.old_lvl = old_lvl[g];
            kind        = make_kind(trig_hi[g], trig_lo[g]);
            hit[g]      = irq_en[g] & trig_hit(kind, smp);
        end
    end
endmodule

// File: rtl/pin_event_status.sv
module pin_event_status #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] hit,
    input  logic [NUM_PINS-1:0] irq_en,
    input  logic                stat_rd,
    output logic [NUM_PINS-1:0] stat_q
);
    logic [NUM_PINS-1:0] keep;
    logic [NUM_PINS-1:0] stat_d;

    always_comb begin
        keep   = stat_rd ? '0 : stat_q;
        stat_d = irq_en & (hit | keep);
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
    import pin_event_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] irq_en,
    input  logic [NUM_PINS-1:0] trig_hi,
    input  logic [NUM_PINS-1:0] trig_lo,
    input  logic                stat_rd,
    output logic [NUM_PINS-1:0] stat_out,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] old_lvl;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] stat_q;
    logic                irq_q;

    pin_event_history #(.NUM_PINS(NUM_PINS)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .old_q  (old_lvl)
    );

    pin_event_match #(.NUM_PINS(NUM_PINS)) u_match (
        .pin_in  (pin_in),
        .old_lvl (old_lvl),
        .irq_en  (irq_en),
        .trig_hi (trig_hi),
        .trig_lo (trig_lo),
        .hit     (hit)
    );

    pin_event_status #(.NUM_PINS(NUM_PINS)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .irq_en  (irq_en),
        .stat_rd (stat_rd),
        .stat_q  (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |stat_q;
    end

    assign stat_out = stat_q;
    assign irq_out  = irq_q;
endmodule

// File: rtl/pin_event_detect_chk.sv
module pin_event_detect_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] irq_en,
    input logic                stat_rd,
    input logic [NUM_PINS-1:0] stat_out,
    input logic                irq_out
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_clear_R1: assert (stat_out == '0 && irq_out == 1'b0)
                else $error("reset did not clear status/irq");
        end
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> (($past(stat_out) & $past(irq_en) & ~stat_out) == '0));

    assert_disabled_clear_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_out & ~$past(irq_en)) == '0));

    assert_irq_or_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|stat_out)));
endmodule

bind pin_event_detect pin_event_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_en   (irq_en),
    .stat_rd  (stat_rd),
    .stat_out (stat_out),
    .irq_out  (irq_out)
);

// File: tb/sim_pin_event_detect.sv
`timescale 1ns/100ps
module sim_pin_event_detect;
    localparam int N = 8;

    typedef struct {
        logic [N-1:0] stat;
        logic         irq;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_in = '0, irq_en = '0, trig_hi = '0, trig_lo = '0;
    logic         stat_rd = 1'b0;
    logic [N-1:0] stat_out;
    logic         irq_out;

    int n_chk = 0, n_fail = 0;
    exp_t q[$];
    logic [N-1:0] m_stat = '0, m_old = '0;
    logic         done = 1'b0;

    always #2.5 clk = ~clk;

    pin_event_detect #(.NUM_PINS(N)) u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .irq_en(irq_en),
        .trig_hi(trig_hi), .trig_lo(trig_lo), .stat_rd(stat_rd),
        .stat_out(stat_out), .irq_out(irq_out)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic [N-1:0] p, input logic [N-1:0] en,
                        input logic [N-1:0] hi, input logic [N-1:0] lo,
                        input logic rd, input string tag);
        exp_t e;
        logic [N-1:0] hit;
        @(negedge clk);
        pin_in = p; irq_en = en; trig_hi = hi; trig_lo = lo; stat_rd = rd;
        for (int i = 0; i < N; i++) begin
            case ({hi[i], lo[i]})
                2'b00: hit[i] = p[i];
                2'b01: hit[i] = ~p[i];
                2'b10: hit[i] = p[i] & ~m_old[i];
                default: hit[i] = ~p[i] & m_old[i];
            endcase
        end
        e.irq  = |m_stat;
        m_stat = en & (hit | (rd ? '0 : m_stat));
        m_old  = p;
        e.stat = m_stat;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(stat_out === e.stat, e.tag, 32'(stat_out), 32'(e.stat));
            check(irq_out === e.irq, "R10 irq", 32'(irq_out), 32'(e.irq));
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(stat_out === '0 && irq_out === 1'b0, "R1 reset", {stat_out, irq_out}, 0);

        // R2 high level on pin 0, then sticky (R6) and read clear (R8)
        step(8'h01, 8'h01, 8'h00, 8'h00, 0, "R2 high level");
        step(8'h00, 8'h01, 8'h00, 8'h00, 0, "R6 sticky");
        step(8'h00, 8'h01, 8'h00, 8'h00, 0, "R6 sticky");
        step(8'h00, 8'h01, 8'h00, 8'h00, 1, "R8 read clear");
        step(8'h00, 8'h01, 8'h00, 8'h00, 0, "R8 stays clear");
        // R3 low level on pin 1, R9 read during active level
        step(8'h02, 8'h02, 8'h00, 8'h02, 0, "R3 low idle high");
        step(8'h00, 8'h02, 8'h00, 8'h02, 0, "R3 low level");
        step(8'h00, 8'h02, 8'h00, 8'h02, 1, "R9 level through read");
        step(8'h02, 8'h02, 8'h00, 8'h02, 1, "R8 clear after level");
        // R4 rising on pin 2
        step(8'h00, 8'h04, 8'h04, 8'h00, 0, "R4 no edge");
        step(8'h04, 8'h04, 8'h04, 8'h00, 0, "R4 rise");
        step(8'h04, 8'h04, 8'h04, 8'h00, 1, "R4 no edge while high");
        step(8'h04, 8'h04, 8'h04, 8'h00, 0, "R4 held high no set");
        // R5 falling on pin 3
        step(8'h08, 8'h08, 8'h08, 8'h08, 0, "R5 high no edge");
        step(8'h00, 8'h08, 8'h08, 8'h08, 0, "R5 fall");
        step(8'h08, 8'h08, 8'h08, 8'h08, 0, "R6 sticky fall");
        // R9 edge during read
        step(8'h00, 8'h08, 8'h08, 8'h08, 1, "R9 fall wins read");
        step(8'h00, 8'h08, 8'h08, 8'h08, 0, "R9 kept");
        // R7 disabled pin ignores condition, disabling clears
        step(8'hFF, 8'h00, 8'h00, 8'h00, 0, "R7 disabled no set");
        step(8'hFF, 8'h10, 8'h00, 8'h00, 0, "R7 enabled sets");
        step(8'hFF, 8'h00, 8'h00, 8'h00, 0, "R7 disable clears");
        // mixed: all kinds together on all pins
        step(8'h00, 8'hFF, 8'hF0, 8'hCC, 1, "R8 mixed clear");
        step(8'hAA, 8'hFF, 8'hF0, 8'hCC, 0, "R4 R5 mixed");
        step(8'h55, 8'hFF, 8'hF0, 8'hCC, 0, "R4 R5 mixed");
        step(8'h55, 8'h0F, 8'hF0, 8'hCC, 1, "R7 R9 mixed");
        // walking bit, per-pin independence
        for (int i = 0; i < N; i++) begin
            step(8'h00, 8'hFF, 8'hFF, 8'h00, 1, "R4 walk base");
            step(8'(1 << i), 8'hFF, 8'hFF, 8'h00, 0, "R4 walk rise");
        end
        step(8'h00, 8'hFF, 8'hFF, 8'h00, 1, "R8 final read");
        step(8'h00, 8'hFF, 8'hFF, 8'h00, 0, "R8 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule